// File: doc/BRIEF.md
# Immediate Prefix Extension Unit

This block builds the 32-bit immediate operand that a 32-bit RISC core feeds to its execute stage. Each decoded instruction arrives with a 16-bit immediate field, a flag that marks its immediate as unsigned, a shift-form flag and its 6-bit major opcode. Without any prefix, the operand is the field sign-extended or zero-extended according to the flag.

A prefix instruction has major opcode 0x2C. It parks its own 16-bit field as a pending upper half and arms a one-shot enable. The next instruction that consumes the enable gets the pending half placed above its own field. This overrides the normal extension of that field.

The operand and the shift amount are combinational from the current field and the registered state. They are valid in the same cycle as the instruction strobe. Only the prefix state is registered.

Top module: `imx_prefix_unit`

## Requirements
- R1: Synchronous active-high reset clears the prefix enable and the pending upper half. A prefix issued before reset has no effect on the first instruction after reset.
- R2: A valid instruction with major opcode 0x2C stores its 16-bit field as the pending upper half and sets the prefix enable from the next cycle on. Its own operand follows the non-prefixed rules.
- R3: While the enable is set, the operand equals the pending upper half in bits 31:16 and the current field in bits 15:0. The unsigned flag has no effect in this case.
- R4: With the enable clear and the unsigned flag set to 1, the operand is the field zero-extended.
- R5: With the enable clear and the unsigned flag set to 0, the operand is the field sign-extended from bit 15.
- R6: When shift_form is 1, shift_amt equals bits 4:0 of the formed operand. When shift_form is 0, shift_amt is 0.
- R7: The enable is cleared after exactly one valid instruction that is not a prefix. The instruction after that one gets normal extension.
- R8: A prefix that follows a prefix replaces the pending upper half and keeps the enable set. The second prefix's own operand uses the first prefix's half.
- R9: Cycles with insn_valid low change neither the enable nor the pending half. This holds even when opcode 0x2C is on the bus in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction strobe for this cycle |
| insn_major | input | 6 | Major opcode of the instruction |
| imm_field | input | 16 | Immediate field of the instruction |
| imm_unsigned | input | 1 | 1 when the immediate is zero-extended |
| shift_form | input | 1 | 1 for the 5-bit shift-amount forms |
| operand | output | 32 | Formed immediate operand |
| shift_amt | output | 5 | Shift amount taken from the operand |

## Verification
The bench targets the one-shot lifetime of the enable. A design that held the enable too long would glue a stale upper half onto the second instruction after a prefix, and one that cleared it too early would lose the half entirely. Back-to-back prefixes check that the newer half wins and that the enable survives. Idle cycles carrying the prefix opcode check that a design ignoring the strobe would wrongly arm. A prefixed instruction marked unsigned, shift forms with high field bits set, and a reset between a prefix and its consumer expose extension mixed into the prefix path, an unmasked shift amount, and state that survives reset.

// File: rtl/imx_pkg.sv
package imx_pkg;
  typedef enum logic [1:0] {
    EXT_SIGN   = 2'd0,
    EXT_ZERO   = 2'd1,
    EXT_PREFIX = 2'd2
  } ext_mode_e;
endpackage

// File: rtl/imx_prefix_state.sv
module imx_prefix_state #(
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             insn_valid,
  input  logic             take_prefix,
  input  logic [IMM_W-1:0] imm_field,
  output logic             armed,
  output logic [IMM_W-1:0] upper
);
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      upper <= '0;
    end else if (insn_valid) begin
      if (take_prefix) begin
        armed <= 1'b1;
        upper <= imm_field;
      end else begin
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/imx_extend.sv
module imx_extend
  import imx_pkg::*;
#(
  parameter int IMM_W = 16,
  localparam int OPND_W = 2 * IMM_W
) (
  input  ext_mode_e         mode,
  input  logic [IMM_W-1:0]  upper,
  input  logic [IMM_W-1:0]  imm_field,
  output logic [OPND_W-1:0] operand
);
  logic [IMM_W-1:0] fill;

  always_comb begin
    unique case (mode)
      EXT_PREFIX: fill = upper;
      EXT_ZERO:   fill = '0;
      default:    fill = {IMM_W{imm_field[IMM_W-1]}};
    endcase
    operand = {fill, imm_field};
  end
endmodule

// File: rtl/imx_shamt.sv
module imx_shamt #(
  parameter int OPND_W  = 32,
  parameter int SHAMT_W = 5
) (
  input  logic [OPND_W-1:0]  operand,
  input  logic               shift_form,
  output logic [SHAMT_W-1:0] shift_amt
);
  generate
    if (SHAMT_W <= OPND_W) begin : g_slice
      assign shift_amt = shift_form ? operand[SHAMT_W-1:0] : '0;
    end else begin : g_pad
      assign shift_amt = shift_form ? {{(SHAMT_W-OPND_W){1'b0}}, operand} : '0;
    end
  endgenerate
endmodule

// File: rtl/imx_prefix_unit.sv
module imx_prefix_unit
  import imx_pkg::*;
#(
  parameter int             IMM_W     = 16,
  parameter int             OP_W      = 6,
  parameter logic [OP_W-1:0] PREFIX_OP = 6'h2C,
  parameter int             SHAMT_W   = 5,
  localparam int            OPND_W    = 2 * IMM_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               insn_valid,
  input  logic [OP_W-1:0]    insn_major,
  input  logic [IMM_W-1:0]   imm_field,
  input  logic               imm_unsigned,
  input  logic               shift_form,
  output logic [OPND_W-1:0]  operand,
  output logic [SHAMT_W-1:0] shift_amt
);
  logic             take_prefix;
  logic             armed;
  logic [IMM_W-1:0] upper;
  ext_mode_e        mode;

  assign take_prefix = insn_valid && (insn_major == PREFIX_OP);

  always_comb begin
    if (armed)             mode = EXT_PREFIX;
    else if (imm_unsigned) mode = EXT_ZERO;
    else                   mode = EXT_SIGN;
  end

  imx_prefix_state #(.IMM_W(IMM_W)) u_state (
    .clk        (clk),
    .rst        (rst),
    .insn_valid (insn_valid),
    .take_prefix(take_prefix),
    .imm_field  (imm_field),
    .armed      (armed),
    .upper      (upper)
  );

  imx_extend #(.IMM_W(IMM_W)) u_ext (
    .mode     (mode),
    .upper    (upper),
    .imm_field(imm_field),
    .operand  (operand)
  );

  imx_shamt #(.OPND_W(OPND_W), .SHAMT_W(SHAMT_W)) u_shamt (
    .operand   (operand),
    .shift_form(shift_form),
    .shift_amt (shift_amt)
  );
endmodule

// File: rtl/imx_prefix_chk.sv
module imx_prefix_chk #(
  parameter int              IMM_W     = 16,
  parameter int              OP_W      = 6,
  parameter logic [OP_W-1:0] PREFIX_OP = 6'h2C,
  parameter int              SHAMT_W   = 5,
  localparam int             OPND_W    = 2 * IMM_W
) (
  input logic               clk,
  input logic               rst,
  input logic               insn_valid,
  input logic [OP_W-1:0]    insn_major,
  input logic [IMM_W-1:0]   imm_field,
  input logic               imm_unsigned,
  input logic               shift_form,
  input logic [OPND_W-1:0]  operand,
  input logic [SHAMT_W-1:0] shift_amt,
  input logic               armed,
  input logic [IMM_W-1:0]   upper
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!armed && upper == '0));

  a_r2_prefix_arms: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn_major == PREFIX_OP) |=> (armed && upper == $past(imm_field)));

  a_r3_prefix_concat: assert property (@(posedge clk) disable iff (rst)
    armed |-> (operand[OPND_W-1:IMM_W] == upper && operand[IMM_W-1:0] == imm_field));

  a_r4_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (!armed && imm_unsigned) |-> (operand[OPND_W-1:IMM_W] == '0));

  a_r5_sign_ext: assert property (@(posedge clk) disable iff (rst)
    (!armed && !imm_unsigned) |-> (operand[OPND_W-1:IMM_W] == {IMM_W{imm_field[IMM_W-1]}}));

  a_r6_shamt: assert property (@(posedge clk) disable iff (rst)
    shift_form |-> (shift_amt == operand[SHAMT_W-1:0]));

  a_r6_shamt_off: assert property (@(posedge clk) disable iff (rst)
    !shift_form |-> (shift_amt == '0));

  a_r7_one_shot: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn_major != PREFIX_OP) |=> !armed);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !insn_valid |=> ($stable(armed) && $stable(upper)));
endmodule

bind imx_prefix_unit imx_prefix_chk #(
  .IMM_W(IMM_W), .OP_W(OP_W), .PREFIX_OP(PREFIX_OP), .SHAMT_W(SHAMT_W)
) u_chk (
  .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_major(insn_major),
  .imm_field(imm_field), .imm_unsigned(imm_unsigned), .shift_form(shift_form),
  .operand(operand), .shift_amt(shift_amt), .armed(armed), .upper(upper)
);

// File: tb/imx_prefix_unit_tb.sv
module imx_prefix_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        insn_valid;
  logic [5:0]  insn_major;
  logic [15:0] imm_field;
  logic        imm_unsigned;
  logic        shift_form;
  logic [31:0] operand;
  logic [4:0]  shift_amt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  imx_prefix_unit dut_i (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_major(insn_major),
    .imm_field(imm_field), .imm_unsigned(imm_unsigned), .shift_form(shift_form),
    .operand(operand), .shift_amt(shift_amt)
  );

  typedef struct packed {
    logic        v;
    logic [5:0]  op;
    logic [15:0] f;
    logic        u;
    logic        s;
    logic [31:0] eo;
    logic [4:0]  es;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 6'h08, 16'h1234, 1'b0, 1'b0, 32'h00001234, 5'h00, 4'd5}, // R5
    '{1'b1, 6'h08, 16'h8001, 1'b0, 1'b0, 32'hFFFF8001, 5'h00, 4'd5}, // R5
    '{1'b1, 6'h08, 16'h8001, 1'b1, 1'b0, 32'h00008001, 5'h00, 4'd4}, // R4
    '{1'b1, 6'h2C, 16'hABCD, 1'b0, 1'b0, 32'hFFFFABCD, 5'h00, 4'd2}, // R2
    '{1'b1, 6'h08, 16'h8001, 1'b0, 1'b0, 32'hABCD8001, 5'h00, 4'd3}, // R3
    '{1'b1, 6'h08, 16'h8001, 1'b0, 1'b0, 32'hFFFF8001, 5'h00, 4'd7}, // R7
    '{1'b1, 6'h2C, 16'h1111, 1'b0, 1'b0, 32'h00001111, 5'h00, 4'd2}, // R2
    '{1'b1, 6'h2C, 16'h2222, 1'b0, 1'b0, 32'h11112222, 5'h00, 4'd8}, // R8
    '{1'b1, 6'h08, 16'h0005, 1'b1, 1'b0, 32'h22220005, 5'h00, 4'd8}, // R8, R3
    '{1'b0, 6'h2C, 16'hFFFF, 1'b0, 1'b0, 32'hFFFFFFFF, 5'h00, 4'd9}, // R9
    '{1'b1, 6'h08, 16'h0003, 1'b0, 1'b0, 32'h00000003, 5'h00, 4'd9}, // R9
    '{1'b1, 6'h2C, 16'h7777, 1'b0, 1'b0, 32'h00007777, 5'h00, 4'd2}, // R2
    '{1'b0, 6'h08, 16'h0001, 1'b0, 1'b0, 32'h77770001, 5'h00, 4'd9}, // R9
    '{1'b0, 6'h08, 16'h0002, 1'b0, 1'b0, 32'h77770002, 5'h00, 4'd9}, // R9
    '{1'b1, 6'h19, 16'h0027, 1'b0, 1'b1, 32'h77770027, 5'h07, 4'd6}, // R6
    '{1'b1, 6'h19, 16'h003F, 1'b0, 1'b1, 32'h0000003F, 5'h1F, 4'd6}, // R6
    '{1'b1, 6'h19, 16'hFFE5, 1'b0, 1'b0, 32'hFFFFFFE5, 5'h00, 4'd6}  // R6
  };

  task automatic drive(input logic v, input logic [5:0] op, input logic [15:0] f,
                       input logic u, input logic s);
    insn_valid = v; insn_major = op; imm_field = f; imm_unsigned = u; shift_form = s;
  endtask

  task automatic check(input int req, input logic [31:0] eo, input logic [4:0] es);
    checks++;
    if (operand !== eo || shift_amt !== es) begin
      errors++;
      $display("FAIL R%0d operand=%h shift_amt=%h expected operand=%h shift_amt=%h",
               req, operand, shift_amt, eo, es);
    end
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b0, 6'h00, 16'h0000, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state, enable clear, sign rule applies
    drive(1'b1, 6'h08, 16'h8000, 1'b0, 1'b0);
    #5 check(1, 32'hFFFF8000, 5'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i].v, VEC[i].op, VEC[i].f, VEC[i].u, VEC[i].s);
      #5 check(int'(VEC[i].req), VEC[i].eo, VEC[i].es);
    end

    // R1: prefix then reset, consumer must see normal extension
    @(negedge clk); drive(1'b1, 6'h2C, 16'h5555, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b1; drive(1'b0, 6'h00, 16'h0000, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0; drive(1'b1, 6'h08, 16'h8000, 1'b0, 1'b0);
    #5 check(1, 32'hFFFF8000, 5'h00);

    // R7: prefix, consumer, then second consumer normal (unsigned)
    @(negedge clk); drive(1'b1, 6'h2C, 16'h00F0, 1'b0, 1'b0);
    @(negedge clk); drive(1'b1, 6'h08, 16'hFFFF, 1'b1, 1'b1);
    #5 check(3, 32'h00F0FFFF, 5'h1F);
    @(negedge clk); drive(1'b1, 6'h08, 16'hFFFF, 1'b1, 1'b0);
    #5 check(7, 32'h0000FFFF, 5'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule